// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is a clocked model of the command logic in a byte-wide flash device that erases in 256-byte sectors. A host drives chip-select, output-enable, write-enable, an address bus and a data bus using asynchronous-style strobes. The controller samples these on the system clock. It decodes two-write command sequences into sector erase and byte program operations and runs those operations on a small internal array under self-timed counters.

While an operation is running, reads do not return array data. They return a status byte. One bit flips on every new read access. The top bit gives a polling value that tells program from erase. Once the operation ends, reads return array contents again. The device comes out of reset write-protected and holds every erase or program command off until a three-write unlock sequence completes. A cancel code aborts a pending setup.

The host data bus is split into an input, an output and an output-enable. An external pad would join them into one bidirectional line.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the controller is in read mode and write-protected, `dq_oe` is 0, and every array byte reads FFh.
- R2: `dq_oe` is 1 only while `ce_n` and `oe_n` are both low and `we_n` is high, apart from a fixed pipeline delay. In read mode with no operation running, a read returns the byte stored at the address.
- R3: While write-protected, the sequences 10h + data and 20h + D0h leave the array unchanged. Protection clears only after three writes in a row: AAh to address 155h, then 55h to 2AAh, then A5h to 155h. A write that does not match the expected step restarts the sequence. If that write matches the first step, it counts as step one.
- R4: Writing 10h and then a write of data D to address A programs A to old AND D, so programming can only clear bits.
- R5: Writing 20h and then D0h to any address sets all 256 bytes of that address's sector (address bits above bit 7) to FFh. Other sectors are left unchanged.
- R6: Writing FFh after either setup code returns to read mode with memory unchanged. Any code other than D0h after the erase setup also returns to read mode without erasing.
- R7: The write address is taken at the moment both `ce_n` and `we_n` have gone low. The write data is the value present just before the first of the two returns high.
- R8: While an operation is running, bit 6 of each new read access is the inverse of bit 6 in the previous access. Once the operation ends, repeated reads return equal data.
- R9: While programming is running, bit 7 of a read is the inverse of bit 7 of the written data. While erasing is running, bit 7 reads 0. Bits 5..0 of the status byte read 0.
- R10: An operation ends by itself within its timer length (PROG_CYC or ERASE_CYC clocks). Writes made while it is running, including setup codes, are ignored.
- R11: The FFh cancel code never turns write protection back on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | Byte address |
| dq_in | input | 8 | Data from host |
| dq_out | output | 8 | Read data or status byte |
| dq_oe | output | 1 | Drive enable for `dq_out`; 0 means high impedance |

## Verification
The hardest situation to reach from the ports is a read that arrives while an erase or program operation is still running. Toggle and polling status are visible only in that window, and the window closes on its own. The bench uses a short program timer and a longer erase timer. It issues reads straight after the confirming write at a fixed access spacing, so the first two reads are known to fall inside the busy window. It then keeps polling until two reads agree. A second hard case is a pair of skewed strobes that changes the address and data buses while a strobe is low. The bench drives that in a dedicated task, with write-enable leading chip-select on the way down and chip-select leading on the way up.

// File: rtl/flash_pkg.sv
package flash_pkg;
  typedef enum logic [2:0] {
    ST_READ,
    ST_ERASE_ARM,
    ST_PROG_ARM,
    ST_ERASING,
    ST_PROGRAMMING
  } fc_state_t;

  localparam logic [7:0] OP_ERASE_ARM = 8'h20;
  localparam logic [7:0] OP_ERASE_GO  = 8'hD0;
  localparam logic [7:0] OP_PROG_ARM  = 8'h10;
  localparam logic [7:0] OP_CANCEL    = 8'hFF;

  localparam logic [7:0] KEY_D0 = 8'hAA;
  localparam logic [7:0] KEY_D1 = 8'h55;
  localparam logic [7:0] KEY_D2 = 8'hA5;
endpackage

// File: rtl/flash_bus_sampler.sv
module flash_bus_sampler #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    dq_in,
  output logic          wr_evt,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          rd_act,
  output logic [AW-1:0] rd_addr
);
  logic          s_wr, wr_prev;
  logic [AW-1:0] s_addr;
  logic [7:0]    s_dq;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_wr    <= 1'b0;
      wr_prev <= 1'b0;
      rd_act  <= 1'b0;
      s_addr  <= '0;
      s_dq    <= '0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      s_wr    <= !ce_n && !we_n;
      rd_act  <= !ce_n && !oe_n && we_n;
      s_addr  <= addr;
      s_dq    <= dq_in;
      wr_prev <= s_wr;
      // later of the two falling strobes: first cycle both are low
      if (s_wr && !wr_prev) wr_addr <= s_addr;
      // data follows the bus until the first strobe rises
      if (s_wr) wr_data <= s_dq;
    end
  end

  assign wr_evt  = wr_prev && !s_wr;
  assign rd_addr = s_addr;

  assert_addr_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (s_wr && wr_prev) |=> $stable(wr_addr));
endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_q,
  input  logic          eng_we,
  input  logic [AW-1:0] eng_addr,
  input  logic [7:0]    eng_wd,
  output logic [7:0]    eng_q
);
  localparam int DEPTH = 2 ** AW;

  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    rd_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (eng_we) mem[eng_addr] <= eng_wd;
    eng_q <= mem[eng_addr];
  end
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_pkg::*;
#(
  parameter int AW = 10,
  parameter int SW = 8,
  parameter int ERASE_CYC = 600,
  parameter int PROG_CYC = 60,
  parameter logic [AW-1:0] KEY_ADDR_A = 10'h155,
  parameter logic [AW-1:0] KEY_ADDR_B = 10'h2AA
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_evt,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  output logic          busy,
  output logic          poll7,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wd,
  input  logic [7:0]    mem_q
);
  localparam int SECTOR_BYTES = 2 ** SW;
  localparam int MAXCYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CW = $clog2(MAXCYC + SECTOR_BYTES) + 1;

  fc_state_t       st;
  logic            prot;
  logic [1:0]      kseq;
  logic [CW-1:0]   cnt;
  logic [AW-SW-1:0] sec;
  logic [AW-1:0]   pa;
  logic [7:0]      pd;

  function automatic logic key_ok(input logic [1:0] s, input logic [AW-1:0] a,
                                  input logic [7:0] d);
    case (s)
      2'd0:    return (a == KEY_ADDR_A) && (d == KEY_D0);
      2'd1:    return (a == KEY_ADDR_B) && (d == KEY_D1);
      default: return (a == KEY_ADDR_A) && (d == KEY_D2);
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_READ;
      prot <= 1'b1;
      kseq <= 2'd0;
      cnt  <= '0;
      sec  <= '0;
      pa   <= '0;
      pd   <= '0;
    end else begin
      case (st)
        ST_READ: begin
          if (wr_evt) begin
            if (key_ok(kseq, wr_addr, wr_data)) begin
              if (kseq == 2'd2) begin
                prot <= 1'b0;
                kseq <= 2'd0;
              end else begin
                kseq <= kseq + 2'd1;
              end
            end else if (key_ok(2'd0, wr_addr, wr_data)) begin
              kseq <= 2'd1;
            end else begin
              kseq <= 2'd0;
            end
            if (!prot && wr_data == OP_ERASE_ARM) st <= ST_ERASE_ARM;
            else if (!prot && wr_data == OP_PROG_ARM) st <= ST_PROG_ARM;
          end
        end
        ST_ERASE_ARM: begin
          if (wr_evt) begin
            if (wr_data == OP_ERASE_GO) begin
              sec <= wr_addr[AW-1:SW];
              cnt <= '0;
              st  <= ST_ERASING;
            end else begin
              st <= ST_READ;
            end
          end
        end
        ST_PROG_ARM: begin
          if (wr_evt) begin
            if (wr_data == OP_CANCEL) begin
              st <= ST_READ;
            end else begin
              pa  <= wr_addr;
              pd  <= wr_data;
              cnt <= '0;
              st  <= ST_PROGRAMMING;
            end
          end
        end
        ST_ERASING: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(ERASE_CYC - 1)) st <= ST_READ;
        end
        ST_PROGRAMMING: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(PROG_CYC - 1)) st <= ST_READ;
        end
        default: st <= ST_READ;
      endcase
    end
  end

  always_comb begin
    mem_we   = 1'b0;
    mem_addr = pa;
    mem_wd   = mem_q & pd;
    if (st == ST_ERASING) begin
      mem_addr = {sec, cnt[SW-1:0]};
      mem_wd   = 8'hFF;
      mem_we   = (cnt < CW'(SECTOR_BYTES));
    end else if (st == ST_PROGRAMMING) begin
      mem_we = (cnt == CW'(1));
    end
  end

  assign busy  = (st == ST_ERASING) || (st == ST_PROGRAMMING);
  assign poll7 = (st == ST_PROGRAMMING) ? ~pd[7] : 1'b0;

  assert_protect_blocks_R3: assert property (@(posedge clk) disable iff (rst)
    (prot && st == ST_READ) |=> (st == ST_READ));
  assert_erase_in_sector_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ERASING && mem_we) |-> (mem_addr[AW-1:SW] == sec));
  assert_timer_bound_R10: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt < CW'(MAXCYC)));
  assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(pa) && $stable(pd) && $stable(sec)));
  assert_cancel_keeps_unlock_R11: assert property (@(posedge clk) disable iff (rst)
    !prot |=> !prot);
endmodule

// File: rtl/flash_status_out.sv
module flash_status_out (
  input  logic       clk,
  input  logic       rst,
  input  logic       rd_act,
  input  logic [7:0] rd_q,
  input  logic       busy,
  input  logic       poll7,
  output logic [7:0] dq_out,
  output logic       dq_oe
);
  logic rd_d, tog;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_d   <= 1'b0;
      tog    <= 1'b0;
      dq_oe  <= 1'b0;
      dq_out <= '0;
    end else begin
      rd_d  <= rd_act;
      if (rd_act && !rd_d && busy) tog <= ~tog;
      dq_oe <= rd_d;
      if (!rd_d)     dq_out <= '0;
      else if (busy) dq_out <= {poll7, tog, 6'b0};
      else           dq_out <= rd_q;
    end
  end

  assert_oe_follows_read_R2: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> $past(rd_act, 2));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int AW = 10,
  parameter int SW = 8,
  parameter int ERASE_CYC = 600,
  parameter int PROG_CYC = 60,
  parameter logic [AW-1:0] KEY_ADDR_A = 10'h155,
  parameter logic [AW-1:0] KEY_ADDR_B = 10'h2AA
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    dq_in,
  output logic [7:0]    dq_out,
  output logic          dq_oe
);
  logic          wr_evt, rd_act, busy, poll7, mem_we;
  logic [AW-1:0] wr_addr, rd_addr, mem_addr;
  logic [7:0]    wr_data, rd_q, mem_wd, mem_q;

  flash_bus_sampler #(.AW(AW)) u_sampler (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .dq_in(dq_in), .wr_evt(wr_evt), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_act(rd_act), .rd_addr(rd_addr)
  );

  flash_cmd_fsm #(
    .AW(AW), .SW(SW), .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC),
    .KEY_ADDR_A(KEY_ADDR_A), .KEY_ADDR_B(KEY_ADDR_B)
  ) u_fsm (
    .clk(clk), .rst(rst), .wr_evt(wr_evt), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .poll7(poll7), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wd(mem_wd), .mem_q(mem_q)
  );

  flash_array #(.AW(AW)) u_array (
    .clk(clk), .rd_addr(rd_addr), .rd_q(rd_q), .eng_we(mem_we),
    .eng_addr(mem_addr), .eng_wd(mem_wd), .eng_q(mem_q)
  );

  flash_status_out u_status (
    .clk(clk), .rst(rst), .rd_act(rd_act), .rd_q(rd_q), .busy(busy),
    .poll7(poll7), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  assert_oe_pins_R2: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> $past(!ce_n && !oe_n && we_n, 3));
endmodule

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [9:0] addr = '0;
  logic [7:0] dq_in = '0;
  logic [7:0] dq_out;
  logic       dq_oe;
  int nvec = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  flash_cmd_ctrl i_flash_cmd_ctrl (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; ce_n = 1'b0;
    @(negedge clk); we_n = 1'b0; dq_in = d;
    repeat (3) @(negedge clk);
    we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic bus_read(input logic [9:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    repeat (5) @(negedge clk);
    d = dq_out;
    chk("R2 dq_oe during read", {7'd0, dq_oe}, 8'h01);
    ce_n = 1'b1; oe_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_done(input string tag, input int max_cyc);
    logic [7:0] r1, r2;
    int cyc = 0;
    bit done = 0;
    while (!done && cyc < max_cyc) begin
      bus_read(10'h000, r1);
      bus_read(10'h000, r2);
      cyc += 20;
      if (r1 == r2) done = 1;
    end
    chk({tag, " R10 completes"}, {7'd0, done}, 8'h01);
  endtask

  task automatic unlock();
    bus_write(10'h155, 8'hAA);
    bus_write(10'h2AA, 8'h55);
    bus_write(10'h155, 8'hA5);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    @(negedge clk);
    chk("R1 dq_oe after reset", {7'd0, dq_oe}, 8'h00);
    bus_read(10'h000, d); chk("R1 erased 000", d, 8'hFF);
    bus_read(10'h3FF, d); chk("R1 erased 3FF", d, 8'hFF);
  endtask

  task automatic t_tristate();
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R2 oe_n high", {7'd0, dq_oe}, 8'h00);
    ce_n = 1'b1; oe_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R2 ce_n high", {7'd0, dq_oe}, 8'h00);
    oe_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_protect();
    logic [7:0] d;
    bus_write(10'h000, 8'h10); bus_write(10'h010, 8'h00);
    bus_write(10'h000, 8'h20); bus_write(10'h010, 8'hD0);
    repeat (20) @(negedge clk);
    bus_read(10'h010, d); chk("R3 protected program", d, 8'hFF);
    // broken sequence: third step wrong, then a retry that reuses step one
    bus_write(10'h155, 8'hAA); bus_write(10'h2AA, 8'h55); bus_write(10'h155, 8'h00);
    bus_write(10'h2AA, 8'h55); bus_write(10'h155, 8'hA5);
    bus_write(10'h000, 8'h10); bus_write(10'h011, 8'h00);
    repeat (80) @(negedge clk);
    bus_read(10'h011, d); chk("R3 deviation restarts", d, 8'hFF);
    // wrong address on step two followed by a new step one
    bus_write(10'h155, 8'hAA); bus_write(10'h155, 8'hAA);
    bus_write(10'h2AA, 8'h55); bus_write(10'h155, 8'hA5);
  endtask

  task automatic t_program();
    logic [7:0] a, b;
    bus_write(10'h000, 8'h10); bus_write(10'h012, 8'h5A);
    bus_read(10'h012, a); bus_read(10'h012, b);
    chk("R9 program poll bit7", {7'd0, a[7]}, 8'h01);
    chk("R9 status low bits", {2'b00, a[5:0]}, 8'h00);
    chk("R8 toggle while programming", {7'd0, a[6] ^ b[6]}, 8'h01);
    wait_done("program", 200);
    bus_read(10'h012, a); chk("R4 programmed value", a, 8'h5A);
    bus_read(10'h012, b); chk("R8 stopped after program", b, a);
    bus_write(10'h000, 8'h10); bus_write(10'h012, 8'h0F);
    // write during busy: arm code ignored
    bus_write(10'h000, 8'h10);
    wait_done("program2", 200);
    bus_write(10'h013, 8'h00);
    repeat (80) @(negedge clk);
    bus_read(10'h012, a); chk("R4 AND of old and new", a, 8'h0A);
    bus_read(10'h013, a); chk("R10 write while busy ignored", a, 8'hFF);
  endtask

  task automatic t_erase();
    logic [7:0] a, b;
    bus_write(10'h000, 8'h10); bus_write(10'h100, 8'h11); wait_done("pe1", 200);
    bus_write(10'h000, 8'h10); bus_write(10'h1FF, 8'h22); wait_done("pe2", 200);
    bus_write(10'h000, 8'h10); bus_write(10'h200, 8'h33); wait_done("pe3", 200);
    bus_write(10'h000, 8'h20); bus_write(10'h1A5, 8'hD0);
    bus_read(10'h000, a); bus_read(10'h000, b);
    chk("R9 erase poll bit7", {7'd0, a[7]}, 8'h00);
    chk("R8 toggle while erasing", {7'd0, a[6] ^ b[6]}, 8'h01);
    wait_done("erase", 1200);
    bus_read(10'h100, a); chk("R5 sector first byte", a, 8'hFF);
    bus_read(10'h1FF, a); chk("R5 sector last byte", a, 8'hFF);
    bus_read(10'h200, a); chk("R5 neighbour kept", a, 8'h33);
    bus_read(10'h012, a); chk("R5 sector 0 kept", a, 8'h0A);
  endtask

  task automatic t_cancel();
    logic [7:0] a;
    bus_write(10'h000, 8'h10); bus_write(10'h000, 8'hFF);
    bus_write(10'h050, 8'h00);
    repeat (80) @(negedge clk);
    bus_read(10'h050, a); chk("R6 program cancelled", a, 8'hFF);
    bus_write(10'h000, 8'h20); bus_write(10'h000, 8'hFF);
    bus_write(10'h200, 8'hD0);
    repeat (700) @(negedge clk);
    bus_read(10'h200, a); chk("R6 erase cancelled", a, 8'h33);
    bus_write(10'h000, 8'h20); bus_write(10'h200, 8'h33);
    bus_write(10'h200, 8'hD0);
    repeat (700) @(negedge clk);
    bus_read(10'h200, a); chk("R6 bad confirm", a, 8'h33);
    bus_write(10'h000, 8'hFF);
    bus_write(10'h000, 8'h10); bus_write(10'h060, 8'h3C);
    wait_done("r11", 200);
    bus_read(10'h060, a); chk("R11 still unlocked", a, 8'h3C);
  endtask

  task automatic t_skew();
    logic [7:0] a;
    bus_write(10'h000, 8'h10);
    @(negedge clk); we_n = 1'b0; addr = 10'h3F0;
    repeat (2) @(negedge clk);
    addr = 10'h070;
    @(negedge clk); ce_n = 1'b0;
    repeat (3) @(negedge clk);
    addr = 10'h071; dq_in = 8'h81;
    repeat (3) @(negedge clk);
    ce_n = 1'b1;
    @(negedge clk); dq_in = 8'h00;
    repeat (2) @(negedge clk);
    we_n = 1'b1;
    repeat (3) @(negedge clk);
    wait_done("skew", 200);
    bus_read(10'h070, a); chk("R7 latched addr and data", a, 8'h81);
    bus_read(10'h071, a); chk("R7 later addr unused", a, 8'hFF);
    bus_read(10'h3F0, a); chk("R7 early addr unused", a, 8'hFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_tristate();
    t_protect();
    t_program();
    t_erase();
    t_cancel();
    t_skew();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule